// File: doc/BRIEF.md
# Raster-Line DMA Slot Arbiter

This block hands out one shared memory bus, one access slot at a time, across a raster line of 225 slots. A free-running slot counter steps once per memory cycle and returns to zero after the last slot of the line. A constant slot map reserves early-line slots for the fixed-rate requesters: DRAM refresh, disk, four audio voices and eight sprites. All other slots, and any reserved slot whose owner is not asking, go to a priority arbiter. That arbiter serves bitplane fetch inside a programmable window, then the copper, then the blitter, then the CPU.

The blitter and the CPU compete for leftover slots under a priority control bit. With the bit set, the blitter always beats the CPU. With the bit clear, a CPU that has lost three leftover slots in a row to the blitter takes the next one. The outputs are registered. Each clock presents one slot index, the grant for that slot, the sub-channel number for audio and sprite grants, and an end-of-line strobe on the last slot. There is no data path here, so every pin is a plain level signal. Requests are sampled on the edge that registers the decision, and there is no back-pressure.

Top module: `line_slot_arbiter`

## Requirements
- R1: `slot_idx` steps 0, 1, … 224 on consecutive clocks and then returns to 0. `eol` is high exactly while `slot_idx` is 224.
- R2: While `rst` is high at a clock edge, the outputs become `slot_idx`=0, `grant`=0, `grant_chan`=0 and `eol`=0. The first edge with `rst` low presents slot 0.
- R3: Slots 0 to 3 always grant refresh (grant bit 0), giving four refresh slots per line.
- R4: Slots 4 to 6 grant the disk (grant bit 1) when `disk_req` is high. Otherwise they fall through to the leftover arbitration.
- R5: Audio voice n owns slot 7+n and is granted there (grant bit 2, `grant_chan`=n) when `audio_req[n]` is high. Otherwise the slot falls through.
- R6: Sprite n owns slots 11+2n and 12+2n and is granted there (grant bit 3, `grant_chan`=n) when `sprite_req[n]` is high. Otherwise the slots fall through.
- R7: A leftover slot s goes to bitplane fetch (grant bit 4) when `bpl_en` is high and `bpl_start` ≤ s < `bpl_stop`. No more than 80 such grants occur in one line.
- R8: A leftover slot that bitplane does not take goes to the copper (bit 5), else to the blitter (bit 6), else to the CPU (bit 7). With no requester the slot is idle and `grant` is 0.
- R9: With `blit_pri` high, the CPU never wins a leftover slot that the blitter also requests.
- R10: With `blit_pri` low and both the blitter and the CPU requesting, the CPU takes the next leftover slot after losing three leftover slots in a row to the blitter. Continuous requests therefore give the pattern blitter, blitter, blitter, CPU.
- R11: `grant` has at most one bit set. `grant_chan` is 0 for all grants other than audio and sprite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| disk_req | input | 1 | Disk channel wants its reserved slots |
| audio_req | input | 4 | Per-voice audio requests |
| sprite_req | input | 8 | Per-sprite requests |
| bpl_en | input | 1 | Bitplane fetch enabled |
| bpl_start | input | 8 | First slot of the bitplane window |
| bpl_stop | input | 8 | Slot just past the bitplane window |
| copper_req | input | 1 | Copper request |
| blit_req | input | 1 | Blitter request |
| cpu_req | input | 1 | CPU request |
| blit_pri | input | 1 | Blitter keeps slots over the CPU |
| grant | output | 8 | One-hot owner of the presented slot |
| grant_chan | output | 3 | Audio voice or sprite number of the grant |
| slot_idx | output | 8 | Index of the presented slot |
| eol | output | 1 | Last slot of the line |

## Verification
The bench builds the block with its default parameters: a 225-slot line, a bitplane cap of 80 and a CPU starvation limit of 3. A whole line takes only 225 clocks, so every configuration row can be checked slot by slot across a complete line, including the wrap. One row opens a bitplane window of 170 slots, which reaches the cap of 80 in the middle of the line. A second row opens a window over the reserved region, so the cap is met after the reserved slots. The starvation limit of 3 makes the blitter-to-CPU handover appear many times within a single line.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // Owner codes double as grant bit positions.
  typedef enum logic [2:0] {
    OWN_REFRESH = 3'd0,
    OWN_DISK    = 3'd1,
    OWN_AUDIO   = 3'd2,
    OWN_SPRITE  = 3'd3,
    OWN_BPL     = 3'd4,
    OWN_COPPER  = 3'd5,
    OWN_BLIT    = 3'd6,
    OWN_CPU     = 3'd7
  } owner_e;

  localparam int OWNERS = 8;
endpackage

// File: rtl/lsa_slot_counter.sv
module lsa_slot_counter #(
  parameter int SLOTS = 225,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] cnt,
  output logic          last
);
  localparam logic [SW-1:0] LAST_IDX = SW'(SLOTS - 1);

  logic [SW-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign last = (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lsa_fixed_map.sv
module lsa_fixed_map
  import lsa_pkg::*;
#(
  parameter int SW            = 8,
  parameter int REFRESH_SLOTS = 4,
  parameter int DISK_SLOTS    = 3,
  parameter int AUDIO_CHANS   = 4,
  parameter int SPRITE_CHANS  = 8,
  parameter int SPRITE_SLOTS  = 2,
  parameter int CW            = 3
) (
  input  logic [SW-1:0]           slot,
  input  logic                    disk_req,
  input  logic [AUDIO_CHANS-1:0]  audio_req,
  input  logic [SPRITE_CHANS-1:0] sprite_req,
  output logic                    hit,
  output owner_e                  owner,
  output logic [CW-1:0]           chan
);
  localparam int DISK_BASE = REFRESH_SLOTS;
  localparam int AUD_BASE  = DISK_BASE + DISK_SLOTS;
  localparam int SPR_BASE  = AUD_BASE + AUDIO_CHANS;

  localparam logic [SW-1:0] DISK_LO = SW'(DISK_BASE);
  localparam logic [SW-1:0] DISK_HI = SW'(AUD_BASE);

  logic                    ref_hit;
  logic                    disk_hit;
  logic [AUDIO_CHANS-1:0]  aud_hit;
  logic [SPRITE_CHANS-1:0] spr_hit;

  assign ref_hit  = (slot < DISK_LO);
  assign disk_hit = disk_req && (slot >= DISK_LO) && (slot < DISK_HI);

  for (genvar a = 0; a < AUDIO_CHANS; a++) begin : g_aud
    localparam logic [SW-1:0] POS = SW'(AUD_BASE + a);
    assign aud_hit[a] = audio_req[a] && (slot == POS);
  end

  for (genvar s = 0; s < SPRITE_CHANS; s++) begin : g_spr
    localparam logic [SW-1:0] LO = SW'(SPR_BASE + s * SPRITE_SLOTS);
    localparam logic [SW-1:0] HI = SW'(SPR_BASE + (s + 1) * SPRITE_SLOTS);
    assign spr_hit[s] = sprite_req[s] && (slot >= LO) && (slot < HI);
  end

  // Reserved windows never overlap, so at most one source hits.
  always_comb begin
    hit   = 1'b0;
    owner = OWN_REFRESH;
    chan  = '0;
    if (ref_hit) begin
      hit = 1'b1;
    end else if (disk_hit) begin
      hit   = 1'b1;
      owner = OWN_DISK;
    end else begin
      for (int a = 0; a < AUDIO_CHANS; a++) begin
        if (aud_hit[a]) begin
          hit   = 1'b1;
          owner = OWN_AUDIO;
          chan  = CW'(a);
        end
      end
      for (int s = 0; s < SPRITE_CHANS; s++) begin
        if (spr_hit[s]) begin
          hit   = 1'b1;
          owner = OWN_SPRITE;
          chan  = CW'(s);
        end
      end
    end
  end
endmodule

// File: rtl/lsa_leftover_arb.sv
module lsa_leftover_arb
  import lsa_pkg::*;
#(
  parameter int SW         = 8,
  parameter int BPL_MAX    = 80,
  parameter int CPU_STARVE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] slot,
  input  logic          line_end,
  input  logic          free,
  input  logic          bpl_en,
  input  logic [SW-1:0] bpl_start,
  input  logic [SW-1:0] bpl_stop,
  input  logic          copper_req,
  input  logic          blit_req,
  input  logic          cpu_req,
  input  logic          blit_pri,
  output logic          valid,
  output owner_e        owner
);
  localparam int BCW = $clog2(BPL_MAX + 1);
  localparam int STW = $clog2(CPU_STARVE + 1);
  localparam logic [BCW-1:0] BPL_CAP   = BCW'(BPL_MAX);
  localparam logic [STW-1:0] STARVE_LIM = STW'(CPU_STARVE);

  logic [BCW-1:0] bpl_cnt_q;
  logic [STW-1:0] starve_q;
  logic           bpl_ok;
  logic           cpu_turn;

  assign bpl_ok   = bpl_en && (slot >= bpl_start) && (slot < bpl_stop) &&
                    (bpl_cnt_q < BPL_CAP);
  assign cpu_turn = !blit_pri && (starve_q >= STARVE_LIM);

  always_comb begin
    valid = 1'b0;
    owner = OWN_CPU;
    if (free) begin
      valid = 1'b1;
      if (bpl_ok)                    owner = OWN_BPL;
      else if (copper_req)           owner = OWN_COPPER;
      else if (blit_req && cpu_req)  owner = cpu_turn ? OWN_CPU : OWN_BLIT;
      else if (blit_req)             owner = OWN_BLIT;
      else if (cpu_req)              owner = OWN_CPU;
      else                           valid = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bpl_cnt_q <= '0;
      starve_q  <= '0;
    end else begin
      if (line_end)                                 bpl_cnt_q <= '0;
      else if (valid && owner == OWN_BPL)           bpl_cnt_q <= bpl_cnt_q + 1'b1;

      if (blit_pri || !cpu_req)                     starve_q <= '0;
      else if (valid && owner == OWN_CPU)           starve_q <= '0;
      else if (valid && owner == OWN_BLIT && starve_q < STARVE_LIM)
                                                    starve_q <= starve_q + 1'b1;
    end
  end
endmodule

// File: rtl/line_slot_arbiter.sv
module line_slot_arbiter
  import lsa_pkg::*;
#(
  parameter int SLOTS         = 225,
  parameter int REFRESH_SLOTS = 4,
  parameter int DISK_SLOTS    = 3,
  parameter int AUDIO_CHANS   = 4,
  parameter int SPRITE_CHANS  = 8,
  parameter int SPRITE_SLOTS  = 2,
  parameter int BPL_MAX       = 80,
  parameter int CPU_STARVE    = 3,
  localparam int SW   = $clog2(SLOTS),
  localparam int MAXC = (AUDIO_CHANS > SPRITE_CHANS) ? AUDIO_CHANS : SPRITE_CHANS,
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    disk_req,
  input  logic [AUDIO_CHANS-1:0]  audio_req,
  input  logic [SPRITE_CHANS-1:0] sprite_req,
  input  logic                    bpl_en,
  input  logic [SW-1:0]           bpl_start,
  input  logic [SW-1:0]           bpl_stop,
  input  logic                    copper_req,
  input  logic                    blit_req,
  input  logic                    cpu_req,
  input  logic                    blit_pri,
  output logic [OWNERS-1:0]       grant,
  output logic [CW-1:0]           grant_chan,
  output logic [SW-1:0]           slot_idx,
  output logic                    eol
);
  logic [SW-1:0] cnt;
  logic          last;
  logic          map_hit;
  owner_e        map_owner;
  logic [CW-1:0] map_chan;
  logic          arb_valid;
  owner_e        arb_owner;

  logic [OWNERS-1:0] grant_d, grant_q;
  logic [CW-1:0]     chan_d, chan_q;
  logic [SW-1:0]     slot_q;
  logic              eol_q;

  lsa_slot_counter #(.SLOTS(SLOTS), .SW(SW)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt), .last(last)
  );

  lsa_fixed_map #(
    .SW(SW), .REFRESH_SLOTS(REFRESH_SLOTS), .DISK_SLOTS(DISK_SLOTS),
    .AUDIO_CHANS(AUDIO_CHANS), .SPRITE_CHANS(SPRITE_CHANS),
    .SPRITE_SLOTS(SPRITE_SLOTS), .CW(CW)
  ) u_map (
    .slot(cnt), .disk_req(disk_req), .audio_req(audio_req),
    .sprite_req(sprite_req), .hit(map_hit), .owner(map_owner), .chan(map_chan)
  );

  lsa_leftover_arb #(.SW(SW), .BPL_MAX(BPL_MAX), .CPU_STARVE(CPU_STARVE)) u_arb (
    .clk(clk), .rst(rst), .slot(cnt), .line_end(last), .free(!map_hit),
    .bpl_en(bpl_en), .bpl_start(bpl_start), .bpl_stop(bpl_stop),
    .copper_req(copper_req), .blit_req(blit_req), .cpu_req(cpu_req),
    .blit_pri(blit_pri), .valid(arb_valid), .owner(arb_owner)
  );

  always_comb begin
    grant_d = '0;
    chan_d  = '0;
    if (map_hit) begin
      grant_d[map_owner] = 1'b1;
      chan_d             = map_chan;
    end else if (arb_valid) begin
      grant_d[arb_owner] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      chan_q  <= '0;
      slot_q  <= '0;
      eol_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      chan_q  <= chan_d;
      slot_q  <= cnt;
      eol_q   <= last;
    end
  end

  assign grant      = grant_q;
  assign grant_chan = chan_q;
  assign slot_idx   = slot_q;
  assign eol        = eol_q;
endmodule

// File: rtl/line_slot_arbiter_checks.sv
module line_slot_arbiter_checks
  import lsa_pkg::*;
#(
  parameter int SLOTS = 225,
  parameter int SW    = 8,
  parameter int REFRESH_SLOTS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [OWNERS-1:0] grant,
  input logic [SW-1:0]     slot_idx,
  input logic              eol,
  input logic              blit_pri,
  input logic              blit_req,
  input logic [SW-1:0]     bpl_start,
  input logic [SW-1:0]     bpl_stop
);
  localparam logic [SW-1:0] LAST_IDX = SW'(SLOTS - 1);
  localparam logic [SW-1:0] REF_END  = SW'(REFRESH_SLOTS);

  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (started && slot_idx == LAST_IDX) |=> (slot_idx == '0));

  assert_eol_last_R1: assert property (@(posedge clk) disable iff (rst)
    eol |-> (slot_idx == LAST_IDX));

  assert_refresh_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (started && slot_idx < REF_END) |-> grant[OWN_REFRESH]);

  assert_blit_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (started && $past(blit_pri && blit_req)) |-> !grant[OWN_CPU]);

  assert_bpl_window_R7: assert property (@(posedge clk) disable iff (rst)
    (started && grant[OWN_BPL]) |->
      (slot_idx >= $past(bpl_start) && slot_idx < $past(bpl_stop)));
endmodule

bind line_slot_arbiter line_slot_arbiter_checks #(
  .SLOTS(SLOTS), .SW(SW), .REFRESH_SLOTS(REFRESH_SLOTS)
) u_checks (
  .clk(clk), .rst(rst), .grant(grant), .slot_idx(slot_idx), .eol(eol),
  .blit_pri(blit_pri), .blit_req(blit_req),
  .bpl_start(bpl_start), .bpl_stop(bpl_stop)
);

// File: tb/line_slot_arbiter_test.sv
`timescale 1ns/1ps
module line_slot_arbiter_test;
  localparam int SLOTS = 225;
  localparam int NV    = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disk_req = 1'b0;
  logic [3:0] audio_req = '0;
  logic [7:0] sprite_req = '0;
  logic       bpl_en = 1'b0;
  logic [7:0] bpl_start = '0;
  logic [7:0] bpl_stop = '0;
  logic       copper_req = 1'b0;
  logic       blit_req = 1'b0;
  logic       cpu_req = 1'b0;
  logic       blit_pri = 1'b0;
  logic [7:0] grant;
  logic [2:0] grant_chan;
  logic [7:0] slot_idx;
  logic       eol;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  line_slot_arbiter uut (
    .clk(clk), .rst(rst), .disk_req(disk_req), .audio_req(audio_req),
    .sprite_req(sprite_req), .bpl_en(bpl_en), .bpl_start(bpl_start),
    .bpl_stop(bpl_stop), .copper_req(copper_req), .blit_req(blit_req),
    .cpu_req(cpu_req), .blit_pri(blit_pri), .grant(grant),
    .grant_chan(grant_chan), .slot_idx(slot_idx), .eol(eol)
  );

  // Row layout: [33] disk, [32:29] audio, [28:21] sprite, [20] bpl_en,
  // [19:12] start, [11:4] stop, [3] copper, [2] blit, [1] cpu, [0] pri
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 4'h0, 8'h00, 1'b0, 8'd0,   8'd0,   1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 4'hF, 8'hFF, 1'b0, 8'd0,   8'd0,   1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 4'h6, 8'hA5, 1'b0, 8'd0,   8'd0,   1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 4'h0, 8'h00, 1'b1, 8'd30,  8'd200, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 4'h0, 8'h00, 1'b0, 8'd0,   8'd0,   1'b0, 1'b1, 1'b1, 1'b1},
    {1'b0, 4'h0, 8'h00, 1'b0, 8'd0,   8'd0,   1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 4'h0, 8'h00, 1'b1, 8'd20,  8'd60,  1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 4'h8, 8'h00, 1'b1, 8'd100, 8'd100, 1'b0, 1'b0, 1'b1, 1'b0},
    {1'b0, 4'h0, 8'h01, 1'b1, 8'd0,   8'd225, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [33:0] v);
    disk_req   = v[33];
    audio_req  = v[32:29];
    sprite_req = v[28:21];
    bpl_en     = v[20];
    bpl_start  = v[19:12];
    bpl_stop   = v[11:4];
    copper_req = v[3];
    blit_req   = v[2];
    cpu_req    = v[1];
    blit_pri   = v[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R2 slot", slot_idx, 0);
    chk("R2 grant", grant, 0);
    chk("R2 chan", grant_chan, 0);
    chk("R2 eol", eol, 0);
    rst = 1'b0;
  endtask

  // Checks one whole line slot by slot against a model built from R1-style rules.
  task automatic run_line(input logic [33:0] v);
    int starve = 0;
    int bcnt   = 0;
    apply(v);
    do_reset();
    for (int s = 0; s < SLOTS; s++) begin
      int    eg = 0;
      int    ec = 0;
      string tag = "R8 idle";
      @(posedge clk);
      @(negedge clk);
      if (blit_pri || !cpu_req) starve = 0;
      if (s < 4) begin
        eg = 1; tag = "R3 refresh";
      end else if (s < 7 && disk_req) begin
        eg = 2; tag = "R4 disk";
      end else if (s >= 7 && s < 11 && audio_req[s-7]) begin
        eg = 4; ec = s - 7; tag = "R5 audio";
      end else if (s >= 11 && s < 27 && sprite_req[(s-11)/2]) begin
        eg = 8; ec = (s - 11) / 2; tag = "R6 sprite";
      end else if (bpl_en && s >= int'(bpl_start) && s < int'(bpl_stop) && bcnt < 80) begin
        eg = 16; bcnt++; tag = "R7 bitplane";
      end else if (copper_req) begin
        eg = 32; tag = "R8 copper";
      end else if (blit_req && cpu_req) begin
        if (blit_pri) begin
          eg = 64; tag = "R9 blitter";
        end else if (starve >= 3) begin
          eg = 128; starve = 0; tag = "R10 cpu turn";
        end else begin
          eg = 64; starve++; tag = "R10 blitter";
        end
      end else if (blit_req) begin
        eg = 64; tag = "R8 blitter";
      end else if (cpu_req) begin
        eg = 128; starve = 0; tag = "R8 cpu";
      end
      chk("R1 slot", slot_idx, s);
      chk("R1 eol", eol, (s == SLOTS - 1) ? 1 : 0);
      chk(tag, grant, eg);
      chk("R11 chan", grant_chan, ec);
      chk("R11 onehot", $countones(grant) <= 1 ? 1 : 0, 1);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1 wrap slot", slot_idx, 0);
    chk("R1 wrap eol", eol, 0);
    chk("R3 wrap refresh", grant, 1);
  endtask

  initial begin
    for (int i = 0; i < NV; i++) run_line(VEC[i]);

    // Directed: reset in mid-line returns to slot 0 with no grant (R2).
    apply(VEC[5]);
    do_reset();
    for (int k = 0; k < 40; k++) @(posedge clk);
    @(negedge clk);
    chk("R1 mid slot", slot_idx, 39);
    do_reset();
    @(posedge clk);
    @(negedge clk);
    chk("R2 restart slot", slot_idx, 0);
    chk("R3 restart refresh", grant, 1);

    // Directed: disabled sprite slot falls through to CPU (R6).
    apply({1'b0, 4'h0, 8'h00, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0});
    do_reset();
    for (int k = 0; k < 12; k++) @(posedge clk);
    @(negedge clk);
    chk("R6 idle sprite slot", slot_idx, 11);
    chk("R6 idle sprite grant", grant, 128);
    chk("R6 idle sprite chan", grant_chan, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule